// File: doc/BRIEF.md
# Half-Duplex Backpressure and Retry Controller

This block controls flow on one half-duplex 10/100 switch port. When the switch reports that its buffers are running short, the block drives a forced carrier-sense signal toward the link partner. The partner then sees a busy medium, defers, and sends nothing. Carrier stays forced until the shortage clears. The block never forces carrier while the port is sending a frame of its own.

The block also sequences the port's own transmissions. A held transmit request starts a frame. A collision ends the attempt. After a collision the controller chooses one of three paths before the next attempt:

- A truncated binary exponential back-off, counted in slot ticks that arrive from outside the block. Because of this, the block does not depend on link speed.
- An immediate retry, used when the aggressive option is set.
- An immediate retry with carrier forced again at once, used when backpressure is active.

In standard behaviour a frame is abandoned after sixteen failed attempts. A second option bit turns that drop off, and the frame is then retried without limit. Both option bits are plain inputs. The value 0 on both gives standard behaviour.

Top module: `hdx_flow_ctrl`

## Requirements
- R1: While reset (`rstN` low) is asserted, `forceCarrier`, `txBusy`, `txStart` and `dropFrame` are all low, and the attempt count is zero.
- R2: Backpressure is `resLow` sampled one cycle earlier. `forceCarrier` is high exactly when backpressure is high and the port is not transmitting. It is released in the cycle after `resLow` is seen low.
- R3: `forceCarrier` and `txBusy` are never high in the same cycle.
- R4: When the port is idle and `txReq` is high, `txStart` pulses for one cycle in the next cycle. `txBusy` is high from that cycle onward. A cycle in which `txDone` is high ends the transmission, and `txBusy` is low in the following cycle.
- R5: A collision during transmission while backpressure is high skips the back-off wait. The port is idle in the next cycle with `forceCarrier` high. A still-held `txReq` restarts the frame one cycle later.
- R6: With `cfgAggressive` high, a collision skips the back-off wait. A held `txReq` then produces `txStart` two cycles after the collision cycle.
- R7: In standard mode, collision number n (counted within the frame) loads a wait of `lfsr & (2^min(n,10) - 1)` slots. The value `lfsr` is taken in the collision cycle. The wait counter decrements once per `slotTick` cycle, and the port returns to idle in the cycle after the counter is seen at zero. `lfsr` is a 16-bit Fibonacci shift register with feedback bits 15, 13, 12 and 10 XOR-ed into bit 0. It is loaded with 0xACE1 in reset and shifts left every cycle after reset.
- R8: With `cfgNoDrop` low, the 16th failed attempt of a frame pulses `dropFrame` for one cycle, returns the port to idle without a wait, and clears the attempt count.
- R9: With `cfgNoDrop` high, no frame is dropped. The attempt count saturates at 16, and the back-off exponent stays at 10.
- R10: A successful end of transmission (`txDone` without `collision`) clears the attempt count. If `collision` and `txDone` are high in the same cycle, the collision takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resLow | input | 1 | Switch buffer resources are low |
| txReq | input | 1 | A frame is waiting; held until it is done or dropped |
| collision | input | 1 | A collision was seen on the medium this cycle |
| txDone | input | 1 | The current frame finished without a collision |
| slotTick | input | 1 | One-cycle strobe marking each slot time |
| cfgAggressive | input | 1 | Retry at once after a collision, with no back-off |
| cfgNoDrop | input | 1 | Never drop a frame on excessive collisions |
| forceCarrier | output | 1 | Forced carrier sense toward the link partner |
| txBusy | output | 1 | The port is transmitting an attempt |
| txStart | output | 1 | One-cycle pulse when an attempt starts |
| dropFrame | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The following properties are checked on every cycle:
- Carrier follows the resource flag and is released when it clears.
- Carrier and transmission never overlap.
- `txStart` and `dropFrame` are single-cycle pulses.
- A drop never occurs with `cfgNoDrop` held.
- Carrier reappears right after a collision under backpressure.
- A collision in aggressive mode leads to a restart two cycles later.

Only the bench's reference model can show the following:
- Wait lengths drawn from the shift register under a growing mask.
- Dropping on exactly the sixteenth failure.
- The attempt count clearing after success or a drop.
- Exponent saturation during unlimited retries.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2
  } hdxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAttempts;
    logic incAttempts;
    logic loadBackoff;
    logic decBackoff;
  } hdxStrobe_t;

endpackage

// File: rtl/hdx_datapath.sv
module hdx_datapath
  import hdx_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int ATT_W = 5,
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  hdxStrobe_t strobe,
  output logic       limitHit,
  output logic       backoffZero
);

  localparam logic [ATT_W-1:0] MAX_A = ATT_W'(MAX_ATTEMPTS);

  logic [LFSR_W-1:0] lfsr;
  logic [ATT_W-1:0]  attempts;
  logic [ATT_W-1:0]  attemptNext;
  logic [CNT_W-1:0]  backoff;
  logic [CNT_W-1:0]  slotMask;

  // saturating failure count, including the collision being handled now
  assign attemptNext = (attempts >= MAX_A) ? MAX_A : attempts + ATT_W'(1);
  assign limitHit    = (attemptNext >= MAX_A);
  assign backoffZero = (backoff == '0);

  // mask of min(n, CNT_W) low ones
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign slotMask[i] = (attemptNext > ATT_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr     <= LFSR_SEED;
      attempts <= '0;
      backoff  <= '0;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & LFSR_TAPS)};
      if (strobe.clrAttempts) begin
        attempts <= '0;
      end else if (strobe.incAttempts) begin
        attempts <= attemptNext;
      end
      if (strobe.loadBackoff) begin
        backoff <= lfsr[CNT_W-1:0] & slotMask;
      end else if (strobe.decBackoff) begin
        backoff <= backoff - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
  import hdx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resLow,
  input  logic       txReq,
  input  logic       collision,
  input  logic       txDone,
  input  logic       slotTick,
  input  logic       cfgAggressive,
  input  logic       cfgNoDrop,
  input  logic       limitHit,
  input  logic       backoffZero,
  output hdxStrobe_t strobe,
  output logic       forceCarrier,
  output logic       txBusy,
  output logic       txStart,
  output logic       dropFrame
);

  hdxState_t state, nextState;
  logic bpActive;
  logic startNext, dropNext;

  always_comb begin
    nextState = state;
    strobe    = '0;
    startNext = 1'b0;
    dropNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (txReq) begin
          nextState = ST_TX;
          startNext = 1'b1;
        end
      end
      ST_TX: begin
        if (collision) begin
          if (limitHit && !cfgNoDrop) begin
            dropNext           = 1'b1;
            strobe.clrAttempts = 1'b1;
            nextState          = ST_IDLE;
          end else begin
            strobe.incAttempts = 1'b1;
            if (bpActive || cfgAggressive) begin
              nextState = ST_IDLE;
            end else begin
              strobe.loadBackoff = 1'b1;
              nextState          = ST_WAIT;
            end
          end
        end else if (txDone) begin
          strobe.clrAttempts = 1'b1;
          nextState          = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (backoffZero) begin
          nextState = ST_IDLE;
        end else if (slotTick) begin
          strobe.decBackoff = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bpActive  <= 1'b0;
      txStart   <= 1'b0;
      dropFrame <= 1'b0;
    end else begin
      state     <= nextState;
      bpActive  <= resLow;
      txStart   <= startNext;
      dropFrame <= dropNext;
    end
  end

  assign txBusy       = (state == ST_TX);
  assign forceCarrier = bpActive && (state != ST_TX);

endmodule

// File: rtl/hdx_flow_ctrl.sv
module hdx_flow_ctrl
  import hdx_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int ATT_W = 5,
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic resLow,
  input  logic txReq,
  input  logic collision,
  input  logic txDone,
  input  logic slotTick,
  input  logic cfgAggressive,
  input  logic cfgNoDrop,
  output logic forceCarrier,
  output logic txBusy,
  output logic txStart,
  output logic dropFrame
);

  hdxStrobe_t strobe;
  logic limitHit;
  logic backoffZero;

  hdx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .resLow       (resLow),
    .txReq        (txReq),
    .collision    (collision),
    .txDone       (txDone),
    .slotTick     (slotTick),
    .cfgAggressive(cfgAggressive),
    .cfgNoDrop    (cfgNoDrop),
    .limitHit     (limitHit),
    .backoffZero  (backoffZero),
    .strobe       (strobe),
    .forceCarrier (forceCarrier),
    .txBusy       (txBusy),
    .txStart      (txStart),
    .dropFrame    (dropFrame)
  );

  hdx_datapath #(
    .LFSR_W      (LFSR_W),
    .LFSR_TAPS   (LFSR_TAPS),
    .LFSR_SEED   (LFSR_SEED),
    .ATT_W       (ATT_W),
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .limitHit   (limitHit),
    .backoffZero(backoffZero)
  );

endmodule

// File: rtl/hdx_flow_chk.sv
module hdx_flow_chk (
  input logic clk,
  input logic rstN,
  input logic resLow,
  input logic txReq,
  input logic collision,
  input logic txDone,
  input logic cfgAggressive,
  input logic cfgNoDrop,
  input logic forceCarrier,
  input logic txBusy,
  input logic txStart,
  input logic dropFrame
);

  // R2
  carrier_assert_chk: assert property (@(posedge clk) disable iff (!rstN)
    resLow |=> (forceCarrier || txBusy));

  // R2
  carrier_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resLow |=> !forceCarrier);

  // R3
  start_no_carrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txBusy && !forceCarrier));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R4
  done_ends_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txDone && !collision) |=> !txBusy);

  // R5
  bp_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && collision && resLow) |=> forceCarrier);

  // R6
  aggr_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && collision && cfgAggressive ##1 txReq) |=> txStart);

  // R8
  drop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropFrame |=> !dropFrame);

  // R8
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropFrame |-> !txBusy);

  // R9
  no_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgNoDrop && $past(cfgNoDrop)) |-> !dropFrame);

endmodule

bind hdx_flow_ctrl hdx_flow_chk u_chk (.*);

// File: tb/hdx_flow_ctrl_tb.sv
module hdx_flow_ctrl_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic resLow = 1'b0, txReq = 1'b0, collision = 1'b0, txDone = 1'b0;
  logic slotTick = 1'b0, cfgAggressive = 1'b0, cfgNoDrop = 1'b0;
  logic forceCarrier, txBusy, txStart, dropFrame;

  hdx_flow_ctrl u_dut (
    .clk(clk), .rstN(rstN), .resLow(resLow), .txReq(txReq),
    .collision(collision), .txDone(txDone), .slotTick(slotTick),
    .cfgAggressive(cfgAggressive), .cfgNoDrop(cfgNoDrop),
    .forceCarrier(forceCarrier), .txBusy(txBusy),
    .txStart(txStart), .dropFrame(dropFrame)
  );

  // reference model state: 0 idle, 1 transmitting, 2 waiting
  int mState = 0, mAtt = 0, mCnt = 0;
  logic [15:0] mLfsr = 16'hACE1;
  bit mBp = 0, mStart = 0, mDrop = 0;

  int checks = 0, fails = 0, drops = 0, cyc = 0;
  int collLeft = 0, busyCnt = 0, slotPer = 0;
  string curReq = "R1";

  always @(posedge clk) begin : model
    int n, k;
    bit fb;
    if (!rstN) begin
      mState = 0; mAtt = 0; mCnt = 0; mLfsr = 16'hACE1;
      mBp = 0; mStart = 0; mDrop = 0;
    end else begin
      fb = mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10];
      mStart = 0;
      mDrop = 0;
      case (mState)
        0: if (txReq) begin mState = 1; mStart = 1; end
        1: begin
          if (collision) begin
            n = (mAtt >= 16) ? 16 : mAtt + 1;
            if (n >= 16 && !cfgNoDrop) begin
              mDrop = 1; mAtt = 0; mState = 0;
            end else begin
              mAtt = n;
              if (mBp || cfgAggressive) mState = 0;
              else begin
                k = (n < 10) ? n : 10;
                mCnt = int'(mLfsr) & ((1 << k) - 1);
                mState = 2;
              end
            end
          end else if (txDone) begin
            mAtt = 0; mState = 0;
          end
        end
        default: begin
          if (mCnt == 0) mState = 0;
          else if (slotTick) mCnt = mCnt - 1;
        end
      endcase
      mBp = resLow;
      mLfsr = {mLfsr[14:0], fb};
    end
  end

  task automatic chk(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", curReq, name, act, exp, cyc);
    end
  endtask

  task automatic chkInt(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, name, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    chk("forceCarrier", forceCarrier, mBp && (mState != 1));
    chk("txBusy", txBusy, mState == 1);
    chk("txStart", txStart, mStart);
    chk("dropFrame", dropFrame, mDrop);
    // R3: carrier and own transmission never overlap
    checks++;
    if (forceCarrier && txBusy) begin
      fails++;
      $display("FAIL R3 overlap: actual 1 expected 0 at cycle %0d", cyc);
    end
    slotTick = (slotPer > 0) && (cyc % slotPer == 0);
    collision = 1'b0;
    txDone = 1'b0;
    if (dropFrame) begin drops++; txReq = 1'b0; end
    if (mState == 1) begin
      busyCnt++;
      if (busyCnt == 2 && txReq) begin
        if (collLeft > 0) begin collision = 1'b1; collLeft--; end
        else begin txDone = 1'b1; txReq = 1'b0; end
      end
    end else begin
      busyCnt = 0;
    end
  endtask

  task automatic runFrame(int nColl);
    collLeft = nColl;
    txReq = 1'b1;
    while (txReq) step();
    repeat (3) step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) step();
    rstN = 1'b1;
    step();

    curReq = "R2";
    resLow = 1'b1;
    repeat (5) step();
    resLow = 1'b0;
    repeat (3) step();

    curReq = "R4";
    runFrame(0);

    curReq = "R7";
    slotPer = 3;
    runFrame(4);

    curReq = "R10";
    runFrame(2);
    runFrame(3);

    curReq = "R6";
    cfgAggressive = 1'b1;
    runFrame(5);
    cfgAggressive = 1'b0;

    curReq = "R5";
    resLow = 1'b1;
    repeat (2) step();
    runFrame(3);
    resLow = 1'b0;
    repeat (2) step();

    curReq = "R3";
    slotPer = 2;
    resLow = 1'b1;
    runFrame(2);
    resLow = 1'b0;
    runFrame(2);

    curReq = "R8";
    slotPer = 1;
    drops = 0;
    runFrame(20);
    chkInt("R8", "drop count", drops, 1);
    runFrame(1);

    curReq = "R9";
    cfgNoDrop = 1'b1;
    drops = 0;
    runFrame(20);
    chkInt("R9", "drop count", drops, 0);
    cfgNoDrop = 1'b0;
    repeat (4) step();

    summary();
    $finish;
  end

endmodule